// File: doc/BRIEF.md
# Twenty-Four Stage Binary Divider with Sectioned Self-Test

The block divides a slow count input by powers of two. It holds a 24-stage binary chain that advances by one on every rising transition of `cnt_in`. Only the seven upper stages are brought out on `taps`, so these taps carry the input divided by 2^18 through 2^24. The whole block runs on one system clock. `cnt_in` is synchronized with two flops, and an edge detector turns each detected rise into a one-cycle step.

A test mode makes the long chain quick to exercise. With `test_mode` high, the chain is cut into three 8-stage sections that all take the same step at once, with no carry between them. From a cleared state, 255 pulses in test mode fill every stage with ones. After returning to serial mode, one further pulse makes the full chain roll over to zero. That rollover is visible as all seven taps falling together. `clear` is an active-high functional clear. It empties every stage and takes priority over both counting and mode changes.

Top module: `ripple_divider24`

## Requirements
- R1: With `rst_n` low, or on the clock edge after `clear` is seen high, every stage is 0, so `taps` reads 0.
- R2: Exactly one increment happens per low-to-high transition of `cnt_in`. Holding `cnt_in` high for many cycles adds no further count. The stages change on the fourth rising `clk` edge after `cnt_in` is first sampled high.
- R3: With `test_mode` low, the 24 stages form one binary counter (stage n is bit n-1). `taps[k]` is bit 17+k, so `taps` equals bits 23 down to 17.
- R4: With `test_mode` high, each of the three 8-bit sections (bits 7:0, 15:8 and 23:16) increments on every step.
- R5: In test mode each section wraps from 255 to 0 on its own, and no carry passes into the next section.
- R6: After a clear, 255 pulses in test mode leave every stage at 1, and `taps` reads 7'h7F.
- R7: From the all-ones state in serial mode, one pulse returns every stage to 0, and `taps` goes from 7'h7F to 0.
- R8: A `clear` that coincides with a count step wins, and the stages end at 0.
- R9: Changing `test_mode` without a step leaves every stage value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clear | input | 1 | Active-high clear of all stages, with priority over counting |
| test_mode | input | 1 | 1 splits the chain into three parallel 8-stage sections |
| cnt_in | input | 1 | Count input; each rising transition adds one |
| taps | output | 7 | Stage outputs 18 to 24 (bits 23:17 of the chain) |

## Verification
The bench fills the sections with random counts in test mode, then switches to serial mode and adds random pulse counts. Sections preloaded near 255 must then carry across section boundaries. A design that leaked carries in test mode, or blocked them in serial mode, shows the wrong tap pattern. Directed cases cover the 255-pulse fill and the single-pulse rollover to zero. They also cover a 256-pulse wrap in test mode, which must read zero rather than a carried value. Further cases hold `cnt_in` high for a long time, toggle the mode with no pulse, and raise `clear` on the same cycle as a pulse. A broken edge detector would count the held level repeatedly, and a mode switch that disturbed the stages would corrupt the preserved value.

// File: rtl/divider_pkg.sv
package divider_pkg;
  localparam int unsigned SECT_W_DEF = 8;
  localparam int unsigned SECT_N_DEF = 3;
  localparam int unsigned TAP_LO_DEF = 17;
endpackage

// File: rtl/count_edge_qual.sv
module count_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic step
);
  logic sync1_q, sync2_q, prev_q, step_q;
  logic step_d;

  always_comb begin
    step_d = sync2_q & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      sync1_q <= raw_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      step_q  <= step_d;
    end
  end

  assign step = step_q;
endmodule

// File: rtl/div_section.sv
module div_section #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         carry
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)   cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign carry = en & (&cnt_q);
endmodule

// File: rtl/ripple_divider24.sv
module ripple_divider24 #(
  parameter int unsigned SECT_W = divider_pkg::SECT_W_DEF,
  parameter int unsigned SECT_N = divider_pkg::SECT_N_DEF,
  parameter int unsigned TAP_LO = divider_pkg::TAP_LO_DEF
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clear,
  input  logic                               test_mode,
  input  logic                               cnt_in,
  output logic [SECT_W*SECT_N-TAP_LO-1:0]    taps
);
  localparam int unsigned CHAIN_W = SECT_W * SECT_N;

  logic                step_q;
  logic [CHAIN_W-1:0]  stages;
  logic [SECT_N-1:0]   sect_en;
  logic [SECT_N-1:0]   sect_carry;

  count_edge_qual u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_in(cnt_in),
    .step  (step_q)
  );

  for (genvar i = 0; i < SECT_N; i++) begin : g_sect
    if (i == 0) begin : g_first
      assign sect_en[i] = step_q;
    end else begin : g_rest
      assign sect_en[i] = test_mode ? step_q : sect_carry[i-1];
    end

    div_section #(.W(SECT_W)) u_sect (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(clear),
      .en   (sect_en[i]),
      .cnt  (stages[i*SECT_W +: SECT_W]),
      .carry(sect_carry[i])
    );
  end

  assign taps = stages[CHAIN_W-1:TAP_LO];
endmodule

// File: rtl/divider_checker.sv
module divider_checker #(
  parameter int unsigned SECT_W = 8,
  parameter int unsigned SECT_N = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clear,
  input logic                     test_mode,
  input logic                     step,
  input logic [SECT_W*SECT_N-1:0] stages
);
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (stages == '0));

  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(stages));

  p_serial_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !test_mode) |=> (stages == $past(stages) + 1'b1));

  for (genvar i = 0; i < SECT_N; i++) begin : g_chk
    p_sect_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && test_mode) |=>
        (stages[i*SECT_W +: SECT_W] == $past(stages[i*SECT_W +: SECT_W]) + 1'b1));
  end
endmodule

bind ripple_divider24 divider_checker #(.SECT_W(SECT_W), .SECT_N(SECT_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .test_mode(test_mode),
  .step     (step_q),
  .stages   (stages)
);

// File: tb/tb_ripple_divider24.sv
module tb_ripple_divider24;
  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic       clear;
  logic       test_mode;
  logic       cnt_in;
  logic [6:0] taps;

  int unsigned n_vec;
  int unsigned n_bad;
  logic [23:0] ref_q;
  bit done;

  ripple_divider24 dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .test_mode(test_mode),
    .cnt_in   (cnt_in),
    .taps     (taps)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] model_step(logic [23:0] v, logic tm);
    logic [23:0] r;
    if (tm) begin
      for (int b = 0; b < 3; b++) r[b*8 +: 8] = v[b*8 +: 8] + 8'd1;
    end else begin
      r = v + 24'd1;
    end
    return r;
  endfunction

  function automatic logic [6:0] model_taps(logic [23:0] v);
    return v[23:17];
  endfunction

  task automatic check(string req, logic [6:0] exp);
    n_vec++;
    if (taps !== exp) begin
      n_bad++;
      $display("FAIL %s: taps=%h expected=%h", req, taps, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) cnt_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_in = 1'b0;
    repeat (3) @(negedge clk);
    ref_q = model_step(ref_q, test_mode);
  endtask

  task automatic pulses(int unsigned n);
    for (int unsigned i = 0; i < n; i++) pulse();
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    ref_q = '0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: taps=%h expected=finish", taps);
      finish_run();
    end
  end

  initial begin
    int unsigned k, n;
    n_vec = 0; n_bad = 0; done = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; clear = 1'b0; test_mode = 1'b0; cnt_in = 1'b0; ref_q = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 7'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", 7'h00);

    // R6: fill via test mode
    test_mode = 1'b1;
    pulses(255);
    check("R6 fill", 7'h7F);
    // R9: mode toggles without a step keep contents
    @(negedge clk) test_mode = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 mode off keeps", 7'h7F);
    @(negedge clk) test_mode = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 mode on keeps", 7'h7F);
    @(negedge clk) test_mode = 1'b0;
    // R7: single pulse rollover
    pulse();
    check("R7 rollover", 7'h00);
    check("R7 model", model_taps(ref_q));

    // R5: 256 pulses in test mode wrap each section to zero
    do_clear();
    test_mode = 1'b1;
    pulses(256);
    check("R5 wrap", 7'h00);
    pulses(44);
    check("R4 parallel count", 7'd22);

    // R2: long high level counts once
    do_clear();
    pulse();
    check("R2 first", model_taps(ref_q));
    @(negedge clk) cnt_in = 1'b1;
    repeat (20) @(negedge clk);
    cnt_in = 1'b0;
    repeat (6) @(negedge clk);
    ref_q = model_step(ref_q, test_mode);
    check("R2 held level", 7'h01);

    // R8: clear coincides with a step
    @(negedge clk) begin cnt_in = 1'b1; clear = 1'b1; end
    repeat (6) @(negedge clk);
    clear = 1'b0; cnt_in = 1'b0;
    repeat (6) @(negedge clk);
    ref_q = '0;
    check("R8 clear priority", 7'h00);

    // Random: preload in test mode, then serial counting (R3, R4)
    for (int t = 0; t < 12; t++) begin
      do_clear();
      test_mode = 1'b1;
      k = $urandom_range(200, 255);
      pulses(k);
      check("R4 random preload", model_taps(ref_q));
      @(negedge clk) test_mode = 1'b0;
      n = $urandom_range(0, 80);
      pulses(n);
      check("R3 random serial", model_taps(ref_q));
    end

    done = 1;
    finish_run();
  end
endmodule